// File: doc/BRIEF.md
# Control packet register write decoder

The decoder sits at the end of a routed packet channel inside a tile and turns incoming 32-bit words into local register writes. The input is a valid/ready stream that carries a last flag. Each group on the stream opens with a header word. The header holds a parity bit, a stream identifier, an operation code, a beat count biased by one, and the byte address of the first register. The data words that follow the header go out one per write on a registered bus made of an address, data and an enable, each to the next word-aligned address.

Several header/data groups may sit back to back in one transfer, so the next header follows directly after the final data word of the previous group. A header with a parity fault or an operation other than write sets a sticky error flag. The data of such a header is still taken from the stream but is never written. A last flag that arrives before the counted end of a group can be treated as a framing error, under the control of a check-enable input. In that case the decoder resynchronises on the following word. The decoder takes one word per cycle and drops ready only while a write is held by a stalled register bus.

Top module: `ctrl_pkt_decoder`

## Requirements
- R1: Out of reset, s_ready_o is 1, wr_en_o is 0 and err_o is 0.
- R2: For a valid header, with bit 31 set so that the header has an odd count of ones and bits 23:22 equal to 0 (write), and with bits 21:20 holding n, the next n+1 words produce n+1 writes in order. Write k goes to address bits 19:0 plus 4*k, modulo 2^20, and carries data word k. A header word never produces a write.
- R3: A write appears on wr_en_o/wr_addr_o/wr_data_o in the cycle after its data word is accepted.
- R4: Header bits 30:24 (stream identifier) have no effect on the writes produced.
- R5: A header with an even count of ones sets err_o. Its n+1 data words are accepted with s_ready_o high, and none of them is written.
- R6: A header whose bits 23:22 are nonzero sets err_o, and its data words are accepted but not written.
- R7: err_o stays at 1 until reset, and later valid groups are still written while it is set.
- R8: A new header may follow the final data word of a group with no gap and no last flag. Both groups are written, and no error is raised.
- R9: With chk_last_en_i at 1, a last flag on a header, or on a data word before the counted final one, sets err_o. That data word is still written, and the next word is taken as a header.
- R10: With chk_last_en_i at 0, an early last flag is ignored. Counting and writing continue, and err_o stays 0.
- R11: While wr_en_o and wr_stall_i are both 1, the write outputs hold stable and s_ready_o is 0. s_ready_o is otherwise 1. A held write completes in the first cycle with wr_stall_i at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| s_data_i | input | 32 | Stream word (header or data) |
| s_valid_i | input | 1 | Stream word valid |
| s_last_i | input | 1 | Last word of transfer |
| s_ready_o | output | 1 | Decoder can take a word |
| chk_last_en_i | input | 1 | Enable framing check on early last |
| wr_en_o | output | 1 | Register write request |
| wr_addr_o | output | 20 | Register byte address |
| wr_data_o | output | 32 | Register write data |
| wr_stall_i | input | 1 | Register bus cannot take the write this cycle |
| err_o | output | 1 | Sticky header or framing error |

## Verification
A pending write can drain on the register bus in the same cycle that the next stream word is accepted. That word may be another data beat or the next group's header. Random bus stalls are applied over back-to-back groups so that stall release and word acceptance coincide. A scoreboard then checks that every write leaves exactly once, in order, with the counted address, and that no header or dropped data slips through. Error detection is also provoked in the same cycle as a valid write: an early last flag lands on a data word that is itself written. The bench then checks both the write and the flag, and checks that the following word is decoded as a header.

// File: rtl/ctrl_pkt_pkg.sv
package ctrl_pkt_pkg;
  typedef enum logic {
    SEQ_HDR  = 1'b0,
    SEQ_DATA = 1'b1
  } seq_st_e;
endpackage

// File: rtl/ctrl_hdr_decode.sv
module ctrl_hdr_decode #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned BEAT_W = 2,
  parameter int unsigned OP_W   = 2,
  parameter logic [OP_W-1:0] WR_OP = '0
) (
  input  logic [DATA_W-1:0] word_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BEAT_W-1:0] beats_o,
  output logic              ok_o
);
  localparam int unsigned BEAT_LSB = ADDR_W;
  localparam int unsigned OP_LSB   = BEAT_LSB + BEAT_W;

  logic [OP_W-1:0] op;
  logic            par_ok;

  assign addr_o  = word_i[ADDR_W-1:0];
  assign beats_o = word_i[BEAT_LSB +: BEAT_W];
  assign op      = word_i[OP_LSB +: OP_W];
  // parity bit makes the whole word odd
  assign par_ok  = ^word_i;
  assign ok_o    = par_ok && (op == WR_OP);
endmodule

// File: rtl/ctrl_pkt_seq.sv
module ctrl_pkt_seq
  import ctrl_pkt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              last_i,
  input  logic              chk_en_i,
  input  logic [ADDR_W-1:0] hdr_addr_i,
  input  logic [BEAT_W-1:0] hdr_beats_i,
  input  logic              hdr_ok_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              err_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);
  localparam logic [BEAT_W-1:0] ONE  = BEAT_W'(1);

  seq_st_e           st_q;
  logic [BEAT_W-1:0] cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              good_q, err_q;
  logic              in_hdr, final_beat, frm_err, hdr_bad;

  assign in_hdr     = (st_q == SEQ_HDR);
  assign final_beat = (cnt_q == '0);
  assign frm_err    = acc_i && chk_en_i && last_i && (in_hdr || !final_beat);
  assign hdr_bad    = acc_i && in_hdr && !hdr_ok_i;

  assign wr_req_o  = acc_i && !in_hdr && good_q;
  assign wr_addr_o = addr_q;
  assign err_o     = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SEQ_HDR;
      cnt_q  <= '0;
      addr_q <= '0;
      good_q <= 1'b0;
    end else if (acc_i) begin
      if (in_hdr) begin
        if (!frm_err) begin
          st_q   <= SEQ_DATA;
          cnt_q  <= hdr_beats_i;
          addr_q <= hdr_addr_i;
          good_q <= hdr_ok_i;
        end
      end else if (final_beat || frm_err) begin
        st_q <= SEQ_HDR;
      end else begin
        cnt_q  <= cnt_q - ONE;
        addr_q <= addr_q + STEP;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 err_q <= 1'b0;
    else if (frm_err || hdr_bad) err_q <= 1'b1;
  end

  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

  // R5
  bad_hdr_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && in_hdr && !hdr_ok_i) |=> err_q);

  // R2
  hdr_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && in_hdr) |-> !wr_req_o);
endmodule

// File: rtl/ctrl_wr_reg.sv
module ctrl_wr_reg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stall_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              held_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else if (load_i) begin
      wr_en_o   <= 1'b1;
      wr_addr_o <= addr_i;
      wr_data_o <= data_i;
    end else if (!stall_i) begin
      wr_en_o <= 1'b0;
    end
  end

  assign held_o = wr_en_o && stall_i;

  // R11
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && stall_i) |=> (wr_en_o && $stable(wr_addr_o) && $stable(wr_data_o)));
endmodule

// File: rtl/ctrl_pkt_decoder.sv
module ctrl_pkt_decoder #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned BEAT_W = 2,
  parameter int unsigned OP_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_valid_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  input  logic              chk_last_en_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_stall_i,
  output logic              err_o
);
  logic [ADDR_W-1:0] hdr_addr, seq_addr;
  logic [BEAT_W-1:0] hdr_beats;
  logic              hdr_ok, acc, wr_req, held;

  assign s_ready_o = !held;
  assign acc       = s_valid_i && s_ready_o;

  ctrl_hdr_decode #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .OP_W(OP_W), .WR_OP('0)
  ) u_hdr (
    .word_i (s_data_i),
    .addr_o (hdr_addr),
    .beats_o(hdr_beats),
    .ok_o   (hdr_ok)
  );

  ctrl_pkt_seq #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BEAT_W(BEAT_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .last_i     (s_last_i),
    .chk_en_i   (chk_last_en_i),
    .hdr_addr_i (hdr_addr),
    .hdr_beats_i(hdr_beats),
    .hdr_ok_i   (hdr_ok),
    .wr_req_o   (wr_req),
    .wr_addr_o  (seq_addr),
    .err_o      (err_o)
  );

  ctrl_wr_reg #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (wr_req),
    .addr_i   (seq_addr),
    .data_i   (s_data_i),
    .stall_i  (wr_stall_i),
    .wr_en_o  (wr_en_o),
    .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o),
    .held_o   (held)
  );

  // R11
  ready_only_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_ready_o |-> (wr_stall_i && wr_en_o));

  // R3
  wr_follows_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !$past(wr_en_o)) |-> $past(acc));
endmodule

// File: tb/ctrl_pkt_decoder_tb_top.sv
`timescale 1ns/100ps
module ctrl_pkt_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_valid = 1'b0, s_last = 1'b0, chk_en = 1'b0;
  logic        s_ready, wr_en, err;
  logic [19:0] wr_addr;
  logic [31:0] wr_data;
  logic        man_stall = 1'b0, rnd_en = 1'b0, stall;
  logic [15:0] lfsr = 16'hACE1;

  int n_cmp = 0, n_bad = 0;
  logic [51:0] exp_q[$];

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    #1 lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end
  assign stall = rnd_en ? lfsr[0] : man_stall;

  ctrl_pkt_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .s_data_i(s_data), .s_valid_i(s_valid), .s_last_i(s_last), .s_ready_o(s_ready),
    .chk_last_en_i(chk_en),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_stall_i(stall), .err_o(err)
  );

  task automatic check(input string req, input logic [51:0] act, input logic [51:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor: a write retires at the next edge when not stalled
  always @(negedge clk) begin
    if (rst_n && wr_en && !stall) begin
      if (exp_q.size() == 0) begin
        check("R2/R5 unexpected write", {wr_addr, wr_data}, 52'h0);
        if ({wr_addr, wr_data} == 52'h0) begin
          n_bad++;
          $display("FAIL R5 unexpected write actual=%h expected=none", {wr_addr, wr_data});
        end
      end else begin
        check("R2 write order", {wr_addr, wr_data}, exp_q.pop_front());
      end
    end
  end

  function automatic logic [31:0] mk_hdr(input logic [6:0] sid, input logic [1:0] op,
                                         input logic [1:0] nb, input logic [19:0] a,
                                         input bit bad_par);
    logic [31:0] h;
    h = {1'b0, sid, op, nb, a};
    h[31] = ~(^h[30:0]) ^ bad_par;
    return h;
  endfunction

  task automatic send_word(input logic [31:0] d, input logic l);
    s_valid = 1'b1; s_data = d; s_last = l;
    forever begin
      @(negedge clk);
      if (s_ready) break;
    end
    @(posedge clk); #1;
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  // one group; expect writes when good
  task automatic send_grp(input logic [6:0] sid, input logic [1:0] op, input logic [1:0] nb,
                          input logic [19:0] a, input logic [31:0] dbase,
                          input bit bad_par, input bit last_end);
    bit good;
    good = (op == 2'd0) && !bad_par;
    send_word(mk_hdr(sid, op, nb, a, bad_par), 1'b0);
    for (int k = 0; k <= int'(nb); k++) begin
      if (good) exp_q.push_back({a + 20'(4 * k), dbase + 32'(k)});
      send_word(dbase + 32'(k), last_end && (k == int'(nb)));
    end
  endtask

  task automatic drain;
    rnd_en = 1'b0; man_stall = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 all writes seen", 52'(exp_q.size()), 52'd0);
    @(posedge clk); #1;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1
    check("R1 reset", {49'd0, s_ready, wr_en, err}, {49'd0, 3'b100});
    @(posedge clk); #1;

    // R2 R3: header gives no write, data appears one cycle after accept
    send_word(mk_hdr(7'd0, 2'd0, 2'd0, 20'h1F000, 1'b0), 1'b0);
    @(negedge clk);
    check("R2 header no write", 52'(wr_en), 52'd0);
    @(posedge clk); #1;
    exp_q.push_back({20'h1F000, 32'd2});
    send_word(32'd2, 1'b1);
    @(negedge clk);
    check("R3 write latency", {wr_en, wr_addr, wr_data[30:0]}, {1'b1, 20'h1F000, 31'd2});
    @(posedge clk); #1;
    drain();

    // R4 R8: back-to-back groups, nonzero stream id, no last between
    send_grp(7'h55, 2'd0, 2'd3, 20'h1F020, 32'h100, 1'b0, 1'b0);
    send_grp(7'h7F, 2'd0, 2'd1, 20'h00040, 32'h200, 1'b0, 1'b1);
    drain();
    check("R8 no error", 52'(err), 52'd0);
    // R2 address wrap
    send_grp(7'h01, 2'd0, 2'd3, 20'hFFFF8, 32'h300, 1'b0, 1'b1);
    drain();

    // R11 directed stall
    man_stall = 1'b1;
    exp_q.push_back({20'h00100, 32'hA0});
    exp_q.push_back({20'h00104, 32'hA1});
    send_word(mk_hdr(7'd0, 2'd0, 2'd1, 20'h00100, 1'b0), 1'b0);
    send_word(32'hA0, 1'b0);
    repeat (3) @(negedge clk);
    check("R11 ready low while held", {50'd0, s_ready, wr_en}, {50'd0, 2'b01});
    check("R11 held addr", 52'(wr_addr), 52'h00100);
    @(posedge clk); #1;
    man_stall = 1'b0;
    send_word(32'hA1, 1'b1);
    drain();

    // R11 R8 random stalls over chained groups
    rnd_en = 1'b1;
    for (int g = 0; g < 12; g++)
      send_grp(7'(g), 2'd0, 2'(g), 20'(g * 64), 32'(g * 16), 1'b0, g == 11);
    drain();
    check("R11 no error after stalls", 52'(err), 52'd0);

    // R5 bad parity, R7 sticky
    do_reset();
    send_grp(7'h03, 2'd0, 2'd2, 20'h00200, 32'hB0, 1'b1, 1'b1);
    drain();
    check("R5 parity error", {50'd0, err, s_ready}, {50'd0, 2'b11});
    send_grp(7'h00, 2'd0, 2'd1, 20'h00300, 32'hC0, 1'b0, 1'b1);
    drain();
    check("R7 sticky", 52'(err), 52'd1);
    do_reset();
    @(negedge clk);
    check("R7 cleared by reset", 52'(err), 52'd0);
    @(posedge clk); #1;

    // R6 unsupported ops
    send_grp(7'h00, 2'd1, 2'd1, 20'h00400, 32'hD0, 1'b0, 1'b0);
    send_grp(7'h00, 2'd3, 2'd0, 20'h00500, 32'hE0, 1'b0, 1'b1);
    drain();
    check("R6 op error", 52'(err), 52'd1);

    // R9 early last on data with check enabled
    do_reset();
    chk_en = 1'b1;
    send_word(mk_hdr(7'd0, 2'd0, 2'd2, 20'h00600, 1'b0), 1'b0);
    exp_q.push_back({20'h00600, 32'hF0});
    send_word(32'hF0, 1'b1);
    send_grp(7'h00, 2'd0, 2'd0, 20'h00700, 32'hF8, 1'b0, 1'b1);
    drain();
    check("R9 early data last", 52'(err), 52'd1);
    // R9 last on header
    do_reset();
    send_word(mk_hdr(7'd0, 2'd0, 2'd1, 20'h00800, 1'b0), 1'b1);
    send_grp(7'h00, 2'd0, 2'd0, 20'h00900, 32'h99, 1'b0, 1'b1);
    drain();
    check("R9 header last", 52'(err), 52'd1);

    // R10 check disabled
    do_reset();
    chk_en = 1'b0;
    send_word(mk_hdr(7'd0, 2'd0, 2'd1, 20'h00A00, 1'b0), 1'b1);
    exp_q.push_back({20'h00A00, 32'h11});
    exp_q.push_back({20'h00A04, 32'h12});
    send_word(32'h11, 1'b1);
    send_word(32'h12, 1'b1);
    drain();
    check("R10 no error", 52'(err), 52'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule